// File: doc/BRIEF.md
# Nonvolatile Byte Memory Access Front End

This block sits between a CPU's byte-wide register bus and a small on-chip nonvolatile data memory. Software programs an address register (split across a low and a high byte), a data register and a control register. It then starts a single-byte read or a single-byte write through control bits. The block drives a request interface toward the memory and takes a completion pulse back. It also raises a level-sensitive ready interrupt.

A stray write can corrupt the memory, so a write needs a two-step unlock. Software first sets a master write-enable bit, which opens a short window that closes on its own. Software then sets the write-enable bit inside that window. A write-enable request outside the window is dropped. A read takes one fixed cycle. A write occupies the memory until the memory reports completion. While a write is busy, the address and data registers are frozen and new requests are refused.

Top module: `nvmem_regif`

## Requirements
- R1: After reset the control register and the data register read 0x00, `irq_ready` is low and `mem_req` is low. The address register has no defined reset value.
- R2: Register select codes on `reg_sel` are 0 for control, 1 for data, 2 for address bits 7:0 and 3 for address bits ADDR_W-1:8 (ADDR_W = 11 by default). A write with `reg_wr` high stores `reg_wdata` into the selected register at the clock edge. `bus_rdata` returns the selected register combinationally.
- R3: Control bits 7:4 and address-high bits 7:ADDR_W-8 always read as zero, whatever was written to them.
- R4: Control bit 3 is ready-interrupt enable, bit 2 is master write enable, bit 1 is write enable (reads 1 while a write is busy) and bit 0 is read enable (reads 1 while a read is in flight). Every control write loads bit 3 from `reg_wdata[3]`.
- R5: A control write with bit 2 set opens the unlock window. Bit 2 reads 1 for exactly UNLOCK_WINDOW (default 4) cycles after that write's edge and then clears by itself. Writing 0 to bit 2 has no effect.
- R6: A control write with bit 1 set, made while bit 2 reads 1 and no access is active, starts a write. From the next cycle `mem_req` and `mem_wr` are high, with `mem_addr` and `mem_wdata` taken from the address and data registers. Bit 1 then reads 1 and bit 2 clears. A bit 1 request made after the window has closed is dropped, bit 1 stays 0 and no request is issued.
- R7: During a write, `mem_req`, `mem_wr`, `mem_addr` and `mem_wdata` hold until `mem_done` is sampled high. Bit 1 clears at that edge. Writes to the address and data registers are ignored while the write is busy.
- R8: A control write with bit 0 set and no access active makes `mem_req` high with `mem_wr` low for exactly one cycle. At the end of that cycle the data register loads `mem_rdata`, and bit 0 then reads 0 again.
- R9: A read request made while a write is busy is ignored: no read is issued and the data register keeps its value. If bit 1 and bit 0 are requested together and the write is accepted, the read is dropped.
- R10: `irq_ready` is high exactly when bit 3 is set, `irq_gie` is high and no write is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_gie | input | 1 | Global interrupt enable |
| irq_ready | output | 1 | Ready interrupt level |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Request is a write (low: read) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the read cycle |
| mem_done | input | 1 | Write completion pulse |

## Verification
The assertions check several properties on every cycle:
- the reserved read-back bits stay zero;
- the unlock window never stays open longer than its length;
- a write only begins right after a cycle with the window open;
- a write request holds stable until completion and clears on it;
- a read lasts one cycle and never overlaps a write;
- the interrupt is never raised during a write or without the global enable.

Only the bench scenarios can show the data paths end to end. These include the exact first and last accepted cycles of the window, a write request dropped one cycle too late, the freezing of address and data during a busy write, and a fetched byte landing in the data register. They also cover the memory contents left behind by a completed write, which a scoreboard compares write by write.

// File: rtl/nvmem_regif_pkg.sv
package nvmem_regif_pkg;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } reg_sel_e;

    // Control register bit positions
    localparam int unsigned CB_RE  = 0;
    localparam int unsigned CB_WE  = 1;
    localparam int unsigned CB_MWE = 2;
    localparam int unsigned CB_RIE = 3;

    // Access sequencer states
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_e;

endpackage

// File: rtl/nvmem_unlock_win.sv
// Self-closing unlock window opened by the master write-enable bit.
module nvmem_unlock_win #(
    parameter int unsigned WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic consume,
    output logic open
);
    localparam int unsigned CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (win_q.open) begin
            if (win_q.cnt <= CNT_LAST) begin
                win_d.open = 1'b0;
                win_d.cnt  = '0;
            end else begin
                win_d.cnt = win_q.cnt - CNT_LAST;
            end
        end
        if (consume) begin
            win_d.open = 1'b0;
            win_d.cnt  = '0;
        end
        if (arm) begin
            win_d.open = 1'b1;
            win_d.cnt  = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign open = win_q.open;
endmodule

// File: rtl/nvmem_access_seq.sv
// Tracks the single outstanding memory access.
module nvmem_access_seq
    import nvmem_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    input  logic mem_done,
    output logic wr_busy,
    output logic rd_active,
    output logic mem_req,
    output logic mem_wr
);
    typedef struct packed {
        acc_state_e st;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ACC_IDLE: begin
                if (start_wr)      seq_d.st = ACC_WRITE;
                else if (start_rd) seq_d.st = ACC_READ;
            end
            ACC_READ:  seq_d.st = ACC_IDLE;
            ACC_WRITE: if (mem_done) seq_d.st = ACC_IDLE;
            default:   seq_d.st = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q.st <= ACC_IDLE;
        else        seq_q    <= seq_d;
    end

    assign wr_busy   = (seq_q.st == ACC_WRITE);
    assign rd_active = (seq_q.st == ACC_READ);
    assign mem_req   = wr_busy | rd_active;
    assign mem_wr    = wr_busy;
endmodule

// File: rtl/nvmem_addr_data.sv
// Address register (no reset) and data register (reset to zero).
module nvmem_addr_data #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_data,
    input  logic [7:0]        wdata,
    input  logic              load,
    input  logic [7:0]        load_data,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);
    localparam int unsigned HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [7:0]        data_d, data_q;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        if (!lock && wr_lo) addr_d[7:0]        = wdata;
        if (!lock && wr_hi) addr_d[ADDR_W-1:8] = wdata[HI_W-1:0];
        if (load)                 data_d = load_data;
        else if (!lock && wr_data) data_d = wdata;
    end

    // The address has no defined reset value, so it gets no reset.
    always_ff @(posedge clk) begin
        addr_q <= addr_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign addr = addr_q;
    assign data = data_q;
endmodule

// File: rtl/nvmem_regif.sv
// Register front end for a byte-wide nonvolatile data memory.
module nvmem_regif
    import nvmem_regif_pkg::*;
#(
    parameter int unsigned ADDR_W        = 11,
    parameter int unsigned UNLOCK_WINDOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              irq_gie,
    output logic              irq_ready,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_done
);
    localparam int unsigned HI_W   = ADDR_W - 8;
    localparam int unsigned HI_PAD = 8 - HI_W;

    typedef struct packed {
        logic rie;
    } top_state_t;

    top_state_t top_d, top_q;

    logic              ctrl_wr, idle;
    logic              start_wr, start_rd, arm;
    logic              win_open, wr_busy, rd_active;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;

    // Request qualification
    assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
    assign idle     = !wr_busy && !rd_active;
    assign start_wr = ctrl_wr && reg_wdata[CB_WE] && win_open && idle;
    assign start_rd = ctrl_wr && reg_wdata[CB_RE] && idle && !start_wr;
    assign arm      = ctrl_wr && reg_wdata[CB_MWE] && !start_wr;

    always_comb begin
        top_d = top_q;
        if (ctrl_wr) top_d.rie = reg_wdata[CB_RIE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    nvmem_unlock_win #(
        .WINDOW (UNLOCK_WINDOW)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .consume (start_wr),
        .open    (win_open)
    );

    nvmem_access_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .mem_done  (mem_done),
        .wr_busy   (wr_busy),
        .rd_active (rd_active),
        .mem_req   (mem_req),
        .mem_wr    (mem_wr)
    );

    nvmem_addr_data #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (wr_busy),
        .wr_lo     (reg_wr && (reg_sel == SEL_ADDR_LO)),
        .wr_hi     (reg_wr && (reg_sel == SEL_ADDR_HI)),
        .wr_data   (reg_wr && (reg_sel == SEL_DATA)),
        .wdata     (reg_wdata),
        .load      (rd_active),
        .load_data (mem_rdata),
        .addr      (addr),
        .data      (data)
    );

    // Read-back multiplexer
    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_CTRL:    bus_rdata = {4'b0000, top_q.rie, win_open, wr_busy, rd_active};
            SEL_DATA:    bus_rdata = data;
            SEL_ADDR_LO: bus_rdata = addr[7:0];
            SEL_ADDR_HI: bus_rdata = {{HI_PAD{1'b0}}, addr[ADDR_W-1:8]};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq_ready = top_q.rie && irq_gie && !wr_busy;
    assign mem_addr  = addr;
    assign mem_wdata = data;
endmodule

// File: rtl/nvmem_regif_chk.sv
module nvmem_regif_chk #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned WINDOW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic [7:0]        bus_rdata,
    input logic              irq_gie,
    input logic              irq_ready,
    input logic              mem_req,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_done,
    input logic              win_open,
    input logic              wr_busy,
    input logic              rd_active
);
    localparam int unsigned RUN_W = $clog2(WINDOW + 2) + 1;

    logic [RUN_W-1:0] open_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        open_run <= '0;
        else if (win_open) open_run <= open_run + 1'b1;
        else               open_run <= '0;
    end

    assert_ctrl_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd0) |-> (bus_rdata[7:4] == 4'h0));

    assert_hi_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (bus_rdata[7:ADDR_W-8] == '0));

    assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        open_run <= RUN_W'(WINDOW));

    assert_wr_from_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(win_open));

    assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wr && !mem_done) |=>
            (mem_req && mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_wr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wr && mem_done) |=> !wr_busy);

    assert_rd_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_wr) |=> !rd_active);

    assert_no_rd_in_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> !rd_active);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ready |-> (irq_gie && !wr_busy));
endmodule

bind nvmem_regif nvmem_regif_chk #(
    .ADDR_W (ADDR_W),
    .WINDOW (UNLOCK_WINDOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .bus_rdata (bus_rdata),
    .irq_gie   (irq_gie),
    .irq_ready (irq_ready),
    .mem_req   (mem_req),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done),
    .win_open  (win_open),
    .wr_busy   (wr_busy),
    .rd_active (rd_active)
);

// File: tb/nvmem_regif_bench.sv
`timescale 1ns/1ps
module nvmem_regif_bench;
    localparam int unsigned ADDR_W  = 11;
    localparam int unsigned MEM_N   = 1 << ADDR_W;
    localparam int unsigned WR_LAT  = 8;
    localparam real         CLK_NS  = 8.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [7:0]        reg_wdata = 8'h00;
    logic [7:0]        bus_rdata;
    logic              irq_gie = 1'b0;
    logic              irq_ready;
    logic              mem_req, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic              mem_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] mem [MEM_N];
    logic [ADDR_W+7:0] exp_q [$];   // {addr, data} of expected writes
    int wr_cnt = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    nvmem_regif #(.ADDR_W(ADDR_W), .UNLOCK_WINDOW(4)) u_nvmem_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .bus_rdata (bus_rdata),
        .irq_gie   (irq_gie),
        .irq_ready (irq_ready),
        .mem_req   (mem_req),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_done  (mem_done)
    );

    function automatic logic [7:0] pattern(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    assign mem_rdata = mem[mem_addr];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Memory model and scoreboard monitor (reacts away from the active edge)
    always @(negedge clk) begin
        if (mem_done) begin
            mem_done <= 1'b0;
            wr_cnt   <= 0;
        end else if (rst_n && mem_req && mem_wr) begin
            if (wr_cnt + 1 == WR_LAT) begin
                mem_done <= 1'b1;
                mem[mem_addr] = mem_wdata;
                if (exp_q.size() == 0) begin
                    check("R6", "unexpected write addr", {21'd0, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    logic [ADDR_W+7:0] item;
                    item = exp_q.pop_front();
                    check("R6", "write address", {21'd0, mem_addr}, {21'd0, item[ADDR_W+7:8]});
                    check("R7", "write data", {24'd0, mem_wdata}, {24'd0, item[7:0]});
                end
            end
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] val);
        reg_sel   = sel;
        reg_wdata = val;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #1;
        val = bus_rdata;
    endtask

    task automatic push_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic wait_write_done();
        logic [7:0] v;
        rd_reg(2'd0, v);
        for (int i = 0; i < 100 && v[1]; i++) begin
            @(negedge clk);
            rd_reg(2'd0, v);
        end
        check("R7", "write-enable cleared on completion", {31'd0, v[1]}, 32'd0);
    endtask

    initial begin
        #(CLK_NS * 150000.0);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < MEM_N; i++) mem[i] = pattern(i);

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_reg(2'd0, v); check("R1", "ctrl after reset", v, 8'h00);
        rd_reg(2'd1, v); check("R1", "data after reset", v, 8'h00);
        check("R1", "irq after reset", irq_ready, 1'b0);
        check("R1", "mem_req after reset", mem_req, 1'b0);

        // R2 register map
        wr_reg(2'd2, 8'h5A);
        wr_reg(2'd3, 8'h03);
        wr_reg(2'd1, 8'hC3);
        rd_reg(2'd2, v); check("R2", "addr low", v, 8'h5A);
        rd_reg(2'd3, v); check("R2", "addr high", v, 8'h03);
        rd_reg(2'd1, v); check("R2", "data", v, 8'hC3);

        // R3 reserved bits
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd3, v); check("R3", "addr high reserved", v, 8'h07);
        wr_reg(2'd0, 8'hF0);
        rd_reg(2'd0, v); check("R3", "ctrl reserved", v, 8'h00);

        // R4 / R10 interrupt enable and level
        wr_reg(2'd0, 8'hF8);
        rd_reg(2'd0, v); check("R4", "rie bit 3", v, 8'h08);
        check("R10", "irq with gie low", irq_ready, 1'b0);
        irq_gie = 1'b1; #1;
        check("R10", "irq with rie and gie", irq_ready, 1'b1);

        // R5 window length, then R6 late request dropped
        wr_reg(2'd0, 8'h0C);
        rd_reg(2'd0, v); check("R5", "mwe set", v, 8'h0C);
        idle(3);
        rd_reg(2'd0, v); check("R5", "mwe in last window cycle", v, 8'h0C);
        idle(1);
        rd_reg(2'd0, v); check("R5", "mwe self-cleared", v, 8'h08);
        wr_reg(2'd0, 8'h0A);
        rd_reg(2'd0, v); check("R6", "late we dropped", v, 8'h08);
        check("R6", "no request after drop", mem_req, 1'b0);
        wr_reg(2'd0, 8'h08);
        rd_reg(2'd0, v); check("R5", "writing 0 to mwe no effect", v, 8'h08);

        // R6 write accepted in the last window slot
        wr_reg(2'd2, 8'h23);
        wr_reg(2'd3, 8'h01);
        wr_reg(2'd1, 8'h9E);
        push_write(11'h123, 8'h9E);
        wr_reg(2'd0, 8'h0C);
        idle(3);
        wr_reg(2'd0, 8'h0A);
        rd_reg(2'd0, v); check("R6", "ctrl during write", v, 8'h0A);
        check("R6", "mem_req write", {mem_req, mem_wr}, 2'b11);
        check("R6", "mem_addr", {21'd0, mem_addr}, 32'h123);
        check("R10", "irq low while busy", irq_ready, 1'b0);

        // R7 frozen registers, R9 read refused during write
        wr_reg(2'd2, 8'h77);
        wr_reg(2'd1, 8'h11);
        wr_reg(2'd0, 8'h09);
        rd_reg(2'd0, v); check("R9", "read refused while busy", v, 8'h0A);
        rd_reg(2'd2, v); check("R7", "addr low frozen", v, 8'h23);
        rd_reg(2'd1, v); check("R7", "data frozen", v, 8'h9E);
        check("R7", "request held", {mem_req, mem_wr}, 2'b11);
        wait_write_done();
        rd_reg(2'd0, v); check("R7", "ctrl after completion", v, 8'h08);
        rd_reg(2'd1, v); check("R9", "data untouched by refused read", v, 8'h9E);
        check("R10", "irq back after write", irq_ready, 1'b1);

        // R8 read back the byte just written
        wr_reg(2'd0, 8'h09);
        rd_reg(2'd0, v); check("R8", "re set during read", v, 8'h09);
        check("R8", "read request", {mem_req, mem_wr}, 2'b10);
        idle(1);
        rd_reg(2'd1, v); check("R8", "fetched byte", v, 8'h9E);
        rd_reg(2'd0, v); check("R8", "re self-cleared", v, 8'h08);
        check("R8", "request released", mem_req, 1'b0);

        // R8 read of preloaded location
        wr_reg(2'd2, 8'hA5);
        wr_reg(2'd3, 8'h02);
        wr_reg(2'd0, 8'h01);
        idle(1);
        rd_reg(2'd1, v); check("R8", "fetched preload", v, pattern(32'h2A5));

        // R6 first window slot, R9 we+re together: write wins
        wr_reg(2'd1, 8'h3C);
        push_write(11'h2A5, 8'h3C);
        wr_reg(2'd0, 8'h04);
        wr_reg(2'd0, 8'h03);
        rd_reg(2'd0, v); check("R9", "we wins over re", v, 8'h02);
        check("R6", "first slot write", {mem_req, mem_wr}, 2'b11);
        wait_write_done();
        rd_reg(2'd1, v); check("R9", "data kept after combined request", v, 8'h3C);
        check("R6", "scoreboard drained", exp_q.size(), 0);
        check("R6", "memory holds write", {24'd0, mem[11'h2A5]}, 32'h3C);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule